// File: doc/BRIEF.md
# Audio Converter Serial Control and Peak-Status Port

This block is the register side of an audio converter's control interface. A host talks to it over a four-wire serial port: a serial clock, an active-low frame enable, a data input and a data output. Each transaction is one 16-bit word sent most significant bit first. The first four bits select a register and the fifth says whether the host reads or writes. The sixth bit is a spare that the block ignores, and the last ten bits carry the payload. Three 10-bit control registers are held here and driven out in parallel to the rest of the converter.

The block also keeps two 6-bit peak-hold registers, one for each audio channel. When tracking is switched on by a control bit, each register holds the largest sample magnitude seen since it was last read, reduced to its top six bits. A read returns the value on the data output during the same frame. The register clears when that frame completes. The serial pins are brought into the system clock domain through synchronisers, so the serial clock must run well below the system clock.

Top module: `audio_ctl_port`

## Requirements
- R1: After reset, all three control outputs are zero and the serial data output is low.
- R2: A frame whose address field (bits 15:12) is 0, 1 or 2 and whose direction bit (bit 11) is 0 writes bits 9:0 into that control register. The write takes effect only when the enable line returns high after the frame, and the other registers are left unchanged.
- R3: A frame that holds any number of serial clock rising edges other than 16 while the enable line is low is discarded: no register is written and no peak register is cleared.
- R4: While the enable line is high, serial clock and data activity changes no register, and the data output stays low.
- R5: A frame with the direction bit set to 1 returns a 16-bit word on the data output, most significant bit first. Bits 15:10 of this word are zero and bits 9:0 hold the addressed register, zero-extended. The data input is sampled on the rising edge of the serial clock, and the data output changes on the falling edge.
- R6: When tracking is enabled, each peak register holds the largest code seen on its channel. The code is the top 6 bits of the 23-bit sample magnitude. The magnitude of the most negative sample saturates to the full-scale positive value. Address 3 reads the left channel and address 4 reads the right channel.
- R7: A complete 16-bit read of a peak address clears that peak register to zero after the frame. The other channel is not affected.
- R8: Peak tracking is enabled by bit 0 of control register 2. While this bit is 0, the peak registers do not change except when a read clears them.
- R9: Addresses 5 to 15 read as zero, and writes to them change no register.
- R10: Writes to the peak addresses 3 and 4 change neither the peak registers nor the control registers.
- R11: The reserved bit (bit 10) has no effect on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_sclk | input | 1 | Serial clock from the host |
| ctl_latch_n | input | 1 | Active-low frame enable |
| ctl_sdi | input | 1 | Serial command data in |
| ctl_sdo | output | 1 | Serial readback data out |
| smp_valid | input | 1 | Strobe marking a new sample pair |
| smp_left | input | SAMPLE_W | Left channel sample, two's complement |
| smp_right | input | SAMPLE_W | Right channel sample, two's complement |
| ctrl0_q | output | CTRL_W | Control register 0 contents |
| ctrl1_q | output | CTRL_W | Control register 1 contents |
| ctrl2_q | output | CTRL_W | Control register 2 contents |

## Verification
The bench sends frames of 15 and 17 bits and toggles the serial clock with the enable line high. A frame counter that commits on any length, or that keeps counting while the enable line is high, would corrupt a control register. The bench sweeps all 64 peak codes with positive and negative samples, including the most negative value. A magnitude function with the wrong slice, or one that does not saturate, returns a code that is wrong by a factor of two or wraps to zero. The bench also reads each peak address twice and runs short reads. A clear that fires on the wrong channel or on a truncated frame then shows up as a lost or stale peak. Reads of unused and peak addresses, writes to them, and a write with the reserved bit set all catch decode that aliases addresses or reads the wrong header bits.

// File: rtl/acp_pkg.sv
package acp_pkg;
  // serial frame layout (fixed by the protocol)
  localparam int FRAME_W  = 16;
  localparam int ADDR_W   = 4;
  localparam int HDR_BITS = 6;            // address + direction + spare
  localparam int CNT_W    = 5;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_BITS - 1);

  typedef enum logic {DIR_WRITE = 1'b0, DIR_READ = 1'b1} dir_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    dir_e              dir;
  } hdr_t;
endpackage

// File: rtl/acp_sync.sv
module acp_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/acp_frame_rx.sv
module acp_frame_rx
  import acp_pkg::*;
#(
  parameter int CTRL_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              latch_n_s,
  input  logic              sdi_s,
  output logic              sclk_rise,
  output logic              sclk_fall,
  output logic              latch_rise,
  output logic              hdr_valid,
  output hdr_t              hdr,
  output logic              frame_done,
  output logic [ADDR_W-1:0] frame_addr,
  output dir_e              frame_dir,
  output logic [CTRL_W-1:0] frame_data,
  output logic [CNT_W-1:0]  bit_cnt
);
  logic               sclk_d, latch_d;
  logic [FRAME_W-1:0] shift_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               active;

  assign active     = ~latch_n_s;
  assign sclk_rise  = sclk_s & ~sclk_d;
  assign sclk_fall  = ~sclk_s & sclk_d;
  assign latch_rise = latch_n_s & ~latch_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      latch_d <= 1'b1;
      shift_q <= '0;
      cnt_q   <= '0;
    end else begin
      sclk_d  <= sclk_s;
      latch_d <= latch_n_s;
      if (!active) begin
        cnt_q <= '0;
      end else if (sclk_rise) begin
        shift_q <= {shift_q[FRAME_W-2:0], sdi_s};
        if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // header complete when the spare bit (6th) arrives: address and direction
  // already sit in the low five bits of the shifter
  assign hdr_valid = active & sclk_rise & (cnt_q == CNT_HDR);
  assign hdr       = hdr_t'(shift_q[HDR_BITS-2:0]);

  assign frame_done = latch_rise & (cnt_q == CNT_FULL);
  assign frame_addr = shift_q[FRAME_W-1 -: ADDR_W];
  assign frame_dir  = dir_e'(shift_q[FRAME_W-1-ADDR_W]);
  assign frame_data = shift_q[CTRL_W-1:0];
  assign bit_cnt    = cnt_q;
endmodule

// File: rtl/acp_peak_hold.sv
module acp_peak_hold #(
  parameter int SAMPLE_W = 24,
  parameter int PEAK_W   = 6,
  parameter int NUM_CH   = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            en,
  input  logic                            smp_valid,
  input  logic [NUM_CH-1:0][SAMPLE_W-1:0] smp,
  input  logic [NUM_CH-1:0]               clr,
  output logic [NUM_CH-1:0][PEAK_W-1:0]   peak_q
);
  localparam int MAG_W = SAMPLE_W - 1;

  // magnitude saturated to MAG_W bits, then its top PEAK_W bits
  function automatic logic [PEAK_W-1:0] peak_code(input logic [SAMPLE_W-1:0] s);
    logic [SAMPLE_W-1:0] mag;
    logic [MAG_W-1:0]    sat;
    mag = s[SAMPLE_W-1] ? (~s + 1'b1) : s;
    sat = mag[SAMPLE_W-1] ? '1 : mag[MAG_W-1:0];
    return sat[MAG_W-1 -: PEAK_W];
  endfunction

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [PEAK_W-1:0] code;
    assign code = peak_code(smp[c]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        peak_q[c] <= '0;
      end else if (clr[c]) begin
        peak_q[c] <= '0;
      end else if (en && smp_valid && (code > peak_q[c])) begin
        peak_q[c] <= code;
      end
    end
  end
endmodule

// File: rtl/acp_regfile.sv
module acp_regfile
  import acp_pkg::*;
#(
  parameter int CTRL_W   = 10,
  parameter int PEAK_W   = 6,
  parameter int NUM_CTRL = 3,
  parameter int NUM_CH   = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [CTRL_W-1:0]               wr_data,
  input  logic [ADDR_W-1:0]               rd_addr,
  input  logic [NUM_CH-1:0][PEAK_W-1:0]   peak,
  output logic [NUM_CTRL-1:0][CTRL_W-1:0] ctrl_q,
  output logic [CTRL_W-1:0]               rd_data
);
  localparam int PAD_W = CTRL_W - PEAK_W;

  for (genvar r = 0; r < NUM_CTRL; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q[r] <= '0;
      end else if (wr_en && (wr_addr == ADDR_W'(r))) begin
        ctrl_q[r] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < NUM_CTRL; r++) begin
      if (rd_addr == ADDR_W'(r)) rd_data = ctrl_q[r];
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_addr == ADDR_W'(NUM_CTRL + c)) rd_data = {{PAD_W{1'b0}}, peak[c]};
    end
  end
endmodule

// File: rtl/acp_tx.sv
module acp_tx #(
  parameter int CTRL_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              sclk_fall,
  input  logic              load,
  input  logic [CTRL_W-1:0] load_data,
  output logic              sdo
);
  logic [CTRL_W-1:0] shift_q;
  logic              armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      armed_q <= 1'b0;
      sdo     <= 1'b0;
    end else if (!active) begin
      shift_q <= '0;
      armed_q <= 1'b0;
      sdo     <= 1'b0;
    end else if (load) begin
      shift_q <= load_data;
      armed_q <= 1'b1;
    end else if (sclk_fall) begin
      sdo <= armed_q & shift_q[CTRL_W-1];
      if (armed_q) shift_q <= {shift_q[CTRL_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/audio_ctl_port.sv
module audio_ctl_port
  import acp_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int CTRL_W      = 10,
  parameter int PEAK_W      = 6,
  parameter int SYNC_STAGES = 2,
  parameter int PEAK_EN_REG = 2,
  parameter int PEAK_EN_BIT = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_sclk,
  input  logic                ctl_latch_n,
  input  logic                ctl_sdi,
  output logic                ctl_sdo,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  output logic [CTRL_W-1:0]   ctrl0_q,
  output logic [CTRL_W-1:0]   ctrl1_q,
  output logic [CTRL_W-1:0]   ctrl2_q
);
  localparam int NUM_CTRL = 3;
  localparam int NUM_CH   = 2;

  // synchronised pins: {sclk, latch_n, sdi}
  logic [2:0] pins_s;
  logic       sclk_s, latch_n_s, sdi_s;

  acp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) i_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ctl_sclk, ctl_latch_n, ctl_sdi}), .q(pins_s)
  );
  assign {sclk_s, latch_n_s, sdi_s} = pins_s;

  // named internal events
  logic              sclk_rise, sclk_fall, latch_rise;
  logic              hdr_valid, frame_done;
  hdr_t              hdr;
  logic [ADDR_W-1:0] frame_addr;
  dir_e              frame_dir;
  logic [CTRL_W-1:0] frame_data;
  logic [CNT_W-1:0]  bit_cnt;
  logic              wr_commit, rd_commit, rd_load, peak_en;
  logic [NUM_CH-1:0] peak_clr;
  logic [CTRL_W-1:0] rd_data;
  logic [NUM_CTRL-1:0][CTRL_W-1:0] ctrl_q;
  logic [NUM_CH-1:0][PEAK_W-1:0]   peak_q;

  acp_frame_rx #(.CTRL_W(CTRL_W)) i_rx (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sclk_s), .latch_n_s(latch_n_s), .sdi_s(sdi_s),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .latch_rise(latch_rise),
    .hdr_valid(hdr_valid), .hdr(hdr),
    .frame_done(frame_done), .frame_addr(frame_addr), .frame_dir(frame_dir),
    .frame_data(frame_data), .bit_cnt(bit_cnt)
  );

  assign wr_commit = frame_done & (frame_dir == DIR_WRITE);
  assign rd_commit = frame_done & (frame_dir == DIR_READ);
  assign rd_load   = hdr_valid & (hdr.dir == DIR_READ);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_clr
    assign peak_clr[c] = rd_commit & (frame_addr == ADDR_W'(NUM_CTRL + c));
  end

  acp_regfile #(.CTRL_W(CTRL_W), .PEAK_W(PEAK_W), .NUM_CTRL(NUM_CTRL), .NUM_CH(NUM_CH)) i_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_commit), .wr_addr(frame_addr), .wr_data(frame_data),
    .rd_addr(hdr.addr), .peak(peak_q),
    .ctrl_q(ctrl_q), .rd_data(rd_data)
  );

  assign peak_en = ctrl_q[PEAK_EN_REG][PEAK_EN_BIT];

  acp_peak_hold #(.SAMPLE_W(SAMPLE_W), .PEAK_W(PEAK_W), .NUM_CH(NUM_CH)) i_peak (
    .clk(clk), .rst_n(rst_n),
    .en(peak_en), .smp_valid(smp_valid),
    .smp({smp_right, smp_left}), .clr(peak_clr),
    .peak_q(peak_q)
  );

  acp_tx #(.CTRL_W(CTRL_W)) i_tx (
    .clk(clk), .rst_n(rst_n),
    .active(~latch_n_s), .sclk_fall(sclk_fall),
    .load(rd_load), .load_data(rd_data),
    .sdo(ctl_sdo)
  );

  assign ctrl0_q = ctrl_q[0];
  assign ctrl1_q = ctrl_q[1];
  assign ctrl2_q = ctrl_q[2];
endmodule

// File: rtl/acp_chk.sv
module acp_chk
  import acp_pkg::*;
#(
  parameter int CTRL_W   = 10,
  parameter int PEAK_W   = 6,
  parameter int NUM_CTRL = 3,
  parameter int NUM_CH   = 2
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            latch_n_s,
  input logic                            latch_rise,
  input logic                            wr_commit,
  input logic                            rd_commit,
  input logic [CNT_W-1:0]                bit_cnt,
  input logic                            sdo,
  input logic                            peak_en,
  input logic [NUM_CH-1:0]               peak_clr,
  input logic [NUM_CTRL-1:0][CTRL_W-1:0] ctrl_q,
  input logic [NUM_CH-1:0][PEAK_W-1:0]   peak_q
);
  // R3
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit || rd_commit) |-> (bit_cnt == CNT_FULL));

  // R2
  commit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit || rd_commit) |-> latch_rise);

  // R2
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_commit) |-> $stable(ctrl_q));

  // R4
  idle_sdo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_n_s && $past(latch_n_s)) |-> !sdo);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pk
    // R6
    peak_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(peak_clr[c]) |-> (peak_q[c] >= $past(peak_q[c])));

    // R7
    peak_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(peak_clr[c]) |-> (peak_q[c] == '0));

    // R8
    peak_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(peak_en) && !$past(peak_clr[c])) |-> $stable(peak_q[c]));
  end
endmodule

bind audio_ctl_port acp_chk #(
  .CTRL_W(CTRL_W), .PEAK_W(PEAK_W), .NUM_CTRL(NUM_CTRL), .NUM_CH(NUM_CH)
) i_acp_chk (
  .clk(clk), .rst_n(rst_n), .latch_n_s(latch_n_s), .latch_rise(latch_rise),
  .wr_commit(wr_commit), .rd_commit(rd_commit), .bit_cnt(bit_cnt),
  .sdo(ctl_sdo), .peak_en(peak_en), .peak_clr(peak_clr),
  .ctrl_q(ctrl_q), .peak_q(peak_q)
);

// File: tb/test_audio_ctl_port.sv
module test_audio_ctl_port;
  localparam int SW = 24;
  localparam int HB = 6;   // system clocks per serial half-bit

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sclk = 1'b0, latch_n = 1'b1, sdi = 1'b0;
  logic          sdo;
  logic          svalid = 1'b0;
  logic [SW-1:0] sl = '0, sr = '0;
  logic [9:0]    c0, c1, c2;
  int            n_chk = 0, n_fail = 0;
  bit            done = 0;

  always #5 clk = ~clk;

  audio_ctl_port i_audio_ctl_port (
    .clk(clk), .rst_n(rst_n), .ctl_sclk(sclk), .ctl_latch_n(latch_n),
    .ctl_sdi(sdi), .ctl_sdo(sdo), .smp_valid(svalid), .smp_left(sl),
    .smp_right(sr), .ctrl0_q(c0), .ctrl1_q(c1), .ctrl2_q(c2)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one frame of nbits, MSB first; rx collects the first 16 bits seen on sdo
  task automatic xfer(input logic [15:0] w, input int nbits, output logic [15:0] rx);
    rx = '0;
    latch_n = 1'b0;
    wait_clk(HB);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? w[15-i] : 1'b0;
      wait_clk(HB);
      if (i < 16) rx = {rx[14:0], sdo};
      sclk = 1'b1;
      wait_clk(HB);
      sclk = 1'b0;
    end
    wait_clk(HB);
    latch_n = 1'b1;
    wait_clk(8);
  endtask

  function automatic logic [15:0] word(input int a, input bit rd, input bit rsv, input logic [9:0] d);
    return {4'(a), rd, rsv, d};
  endfunction

  task automatic wr(input int a, input logic [9:0] d);
    logic [15:0] junk;
    xfer(word(a, 1'b0, 1'b0, d), 16, junk);
  endtask

  task automatic rd(input int a, output logic [15:0] rx);
    xfer(word(a, 1'b1, 1'b0, 10'h0), 16, rx);
  endtask

  task automatic feed(input longint l, input longint r);
    sl = SW'(l);
    sr = SW'(r);
    svalid = 1'b1;
    wait_clk(1);
    svalid = 1'b0;
    wait_clk(1);
  endtask

  // expected 6-bit code: saturated magnitude divided by 2^17
  function automatic logic [15:0] exp_code(input longint s);
    longint m;
    m = (s < 0) ? -s : s;
    if (m > 64'sd8388607) m = 64'sd8388607;
    return 16'(m / 131072);
  endfunction

  initial begin : watchdog
    wait_clk(190000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] rx;
    logic [9:0]  pat;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(4);

    // R1 reset state
    check("R1 ctrl0", 32'(c0), 0);
    check("R1 ctrl1", 32'(c1), 0);
    check("R1 ctrl2", 32'(c2), 0);
    check("R1 sdo", 32'(sdo), 0);

    // R2 / R5 write each register, read it back, check isolation
    for (int k = 0; k < 6; k++) begin
      for (int a = 0; a < 3; a++) begin
        pat = 10'((k * 311 + a * 97 + 5) ^ (10'h2AA >> k));
        wr(a, pat);
        check("R2 target", 32'(a == 0 ? c0 : a == 1 ? c1 : c2), 32'(pat));
        rd(a, rx);
        check("R5 readback", 32'(rx), 32'({6'b0, pat}));
      end
    end
    wr(0, 10'h155); wr(1, 10'h0F0); wr(2, 10'h000);
    check("R2 others ctrl1", 32'(c1), 32'h0F0);
    check("R2 others ctrl0", 32'(c0), 32'h155);

    // R3 short and long frames are discarded
    xfer(word(0, 1'b0, 1'b0, 10'h3FF), 15, rx);
    check("R3 short frame", 32'(c0), 32'h155);
    xfer(word(0, 1'b0, 1'b0, 10'h3FF), 17, rx);
    check("R3 long frame", 32'(c0), 32'h155);

    // R4 serial activity with enable high is ignored
    for (int i = 0; i < 16; i++) begin
      sdi = word(1, 1'b0, 1'b0, 10'h3C3)[15-i];
      wait_clk(HB); sclk = 1'b1;
      wait_clk(HB);
      check("R4 sdo idle", 32'(sdo), 0);
      sclk = 1'b0;
    end
    wait_clk(8);
    check("R4 no write", 32'(c1), 32'h0F0);
    wr(1, 10'h1E1);
    check("R4 next frame ok", 32'(c1), 32'h1E1);

    // R11 reserved bit ignored
    xfer(word(1, 1'b0, 1'b1, 10'h2B4), 16, rx);
    check("R11 reserved set", 32'(c1), 32'h2B4);

    // R9 unused addresses
    for (int a = 5; a < 16; a++) begin
      wr(a, 10'h3FF);
      rd(a, rx);
      check("R9 read zero", 32'(rx), 0);
    end
    check("R9 ctrl0 kept", 32'(c0), 32'h155);
    check("R9 ctrl1 kept", 32'(c1), 32'h2B4);
    check("R9 ctrl2 kept", 32'(c2), 32'h000);

    // R8 disabled tracking: big samples leave peaks at zero
    rd(3, rx); rd(4, rx);
    feed(64'sd8000000, -64'sd8000000);
    rd(3, rx);
    check("R8 left off", 32'(rx), 0);
    rd(4, rx);
    check("R8 right off", 32'(rx), 0);

    // R6 sweep of every code, both signs, both channels
    wr(2, 10'h001);
    for (int k = 0; k < 64; k++) begin
      longint lv, rv;
      lv = longint'((k << 17) + ((k * 977) % 131072));
      rv = longint'(((63 - k) << 17) + ((k * 4099) % 131072));
      if (k % 2 == 1) lv = -lv;
      if (k % 3 == 0) rv = -rv;
      feed(lv, rv);
      rd(3, rx);
      check("R6 left code", 32'(rx), 32'(exp_code(lv)));
      rd(4, rx);
      check("R6 right code", 32'(rx), 32'(exp_code(rv)));
    end

    // R6 extremes
    feed(-64'sd8388608, 64'sd8388607);
    rd(3, rx);
    check("R6 most negative", 32'(rx), 63);
    rd(4, rx);
    check("R6 full positive", 32'(rx), 63);

    // R6 hold maximum; R7 clear only the read channel and only on full frame
    feed(64'sd1000000, 64'sd300000);
    feed(-64'sd5000000, 64'sd200000);
    feed(64'sd2000000, -64'sd100000);
    xfer(word(3, 1'b1, 1'b0, 10'h0), 15, rx);
    rd(3, rx);
    check("R7 short read kept", 32'(rx), 32'(exp_code(5000000)));
    rd(3, rx);
    check("R7 cleared", 32'(rx), 0);
    rd(4, rx);
    check("R7 other channel", 32'(rx), 32'(exp_code(300000)));

    // R10 writes to peak addresses ignored
    feed(64'sd4000000, 64'sd4000000);
    wr(3, 10'h000);
    wr(4, 10'h3FF);
    rd(3, rx);
    check("R10 left kept", 32'(rx), 32'(exp_code(4000000)));
    rd(4, rx);
    check("R10 right kept", 32'(rx), 32'(exp_code(4000000)));
    check("R10 ctrl0", 32'(c0), 32'h155);
    check("R10 ctrl2", 32'(c2), 32'h001);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule